// File: doc/BRIEF.md
# Page Translation Buffer

This block keeps a small, fully associative set of recently used page mappings. It turns a 32-bit virtual address into a 30-bit physical address for 4 KB pages. A lookup compares the 20-bit virtual page number against every stored entry in the same cycle. On a hit the block returns the physical page number joined with the untouched 12-bit page offset, together with the entry's dirty and reference status. On a miss it raises an exception flag in the same cycle. A handler outside the block then loads the mapping through the refill port and retries the access.

Each entry holds a valid bit, a dirty bit and a reference bit. A hit sets the reference bit, and a write hit also sets the dirty bit; both updates land on the next clock edge. A one-cycle clear command zeroes every reference bit, so that software can tell which pages have gone unused since the last sweep. When a refill arrives, the target entry is chosen in this order: an entry that already holds the same page, then a free slot, then an entry not referenced since the last sweep, then a rotating pointer.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit, `pa` equals the entry's 18-bit physical page number concatenated above `lk_vaddr[11:0]`. The virtual page number is `lk_vaddr[31:12]`. The result is combinational in the cycle of the lookup.
- R2: When `lk_valid` is 1 and no valid entry matches, `miss_exc` is 1 and `hit` is 0. In that case `pa`, `hit_dirty` and `hit_ref` are 0, and no entry changes. `hit` and `miss_exc` are never both 1.
- R3: A hit reports in `hit_ref` the reference bit as stored before the access, and sets that bit from the next edge on.
- R4: A hit reports in `hit_dirty` the stored dirty bit. A hit with `lk_write`=1 sets the dirty bit from the next edge on; a read hit leaves it unchanged.
- R5: A cycle with `clr_ref`=1 zeroes every reference bit. If a lookup hits in that same cycle, the hit entry's reference bit ends up 1.
- R6: Reset (`rst_n`=0) invalidates every entry and sets the rotating pointer to 0.
- R7: A refill of a page not present goes to the lowest-index invalid entry, if one exists.
- R8: If all entries are valid, the refill goes to the lowest-index entry whose reference bit is 0.
- R9: If every entry is valid and referenced, the refill goes to the entry named by the rotating pointer. The pointer then advances to that index plus one, wrapping to 0 after the last entry; only a refill placed this way moves it.
- R10: A refill whose page number matches a valid entry overwrites that entry, so no page is held twice.
- R11: A refill stores the page number, the physical page number and `fill_dirty`, with valid 1 and reference 0, visible from the next cycle. When a refill and a lookup update target the same entry in one cycle, the refill wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Lookup is a write access |
| lk_vaddr | input | 32 | Virtual address to translate |
| clr_ref | input | 1 | Zero all reference bits |
| fill_en | input | 1 | Load one entry this cycle |
| fill_vpn | input | 20 | Virtual page number to load |
| fill_ppn | input | 18 | Physical page number to load |
| fill_dirty | input | 1 | Dirty status to load |
| hit | output | 1 | Lookup found a valid entry |
| miss_exc | output | 1 | Lookup missed; access must not complete |
| pa | output | 30 | Translated physical address |
| hit_dirty | output | 1 | Stored dirty bit of the hit entry |
| hit_ref | output | 1 | Stored reference bit of the hit entry |

## Verification
On every cycle, the assertions check that hit and miss never occur together and that a miss only follows a request. They also check that a touched entry's reference and dirty bits are set one edge later, that a lone clear leaves no reference bit set, that a refilled slot becomes valid, and that no page number ever matches two entries. Only the bench scenarios can show the victim order across free, unreferenced and rotating choices, the pointer advancing between rotations, the overwrite of an existing page, and the exact translated addresses with varied offsets. The bench observes all of these at the ports, through later hits and misses.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned PG_OFF_W = 12;

  // How the refill target was picked when no entry holds the same page
  typedef enum logic [1:0] {
    VS_FREE   = 2'd0,
    VS_STALE  = 2'd1,
    VS_ROTATE = 2'd2
  } vsel_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned N     = 16,
  parameter int unsigned VPN_W = 20,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [VPN_W-1:0]          key,
  input  logic [N-1:0]              valid,
  input  logic [N-1:0][VPN_W-1:0]   tags,
  output logic [N-1:0]              match,
  output logic                      any,
  output logic [IDX_W-1:0]          idx
);
  // one comparator per entry, all in parallel
  for (genvar k = 0; k < N; k++) begin : g_cmp
    assign match[k] = valid[k] && (tags[k] == key);
  end

  assign any = |match;

  always_comb begin
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (match[k]) idx = IDX_W'(k);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int unsigned N = 16,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     refd,
  input  logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] vic_idx,
  output vsel_e            vic_how
);
  logic             have_free, have_stale;
  logic [IDX_W-1:0] free_idx, stale_idx;

  always_comb begin
    have_free  = 1'b0;
    have_stale = 1'b0;
    free_idx   = '0;
    stale_idx  = '0;
    // descending scan: the lowest index is written last
    for (int k = N - 1; k >= 0; k--) begin
      if (!valid[k]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(k);
      end
      if (valid[k] && !refd[k]) begin
        have_stale = 1'b1;
        stale_idx  = IDX_W'(k);
      end
    end
  end

  always_comb begin
    if (have_free) begin
      vic_idx = free_idx;
      vic_how = VS_FREE;
    end else if (have_stale) begin
      vic_idx = stale_idx;
      vic_how = VS_STALE;
    end else begin
      vic_idx = ptr;
      vic_how = VS_ROTATE;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned N     = 16,
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PPN_W = 18,
  localparam int unsigned VPN_W = VA_W - PG_OFF_W,
  localparam int unsigned PA_W  = PPN_W + PG_OFF_W,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic             lk_write,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             clr_ref,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_dirty,
  output logic             hit,
  output logic             miss_exc,
  output logic [PA_W-1:0]  pa,
  output logic             hit_dirty,
  output logic             hit_ref
);
  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] p,
                                              input logic [VA_W-1:0]  va);
    return {p, va[PG_OFF_W-1:0]};
  endfunction

  function automatic logic [IDX_W-1:0] next_ptr(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(N - 1)) ? '0 : i + 1'b1;
  endfunction

  // entry storage
  logic [N-1:0][VPN_W-1:0] tag_q;
  logic [N-1:0][PPN_W-1:0] ppn_q;
  logic [N-1:0]            valid_q, dirty_q, ref_q;
  logic [IDX_W-1:0]        ptr_q;

  // lookup side
  logic [VPN_W-1:0] lk_vpn;
  logic [N-1:0]     lk_match;
  logic             lk_any;
  logic [IDX_W-1:0] lk_idx;

  assign lk_vpn = lk_vaddr[VA_W-1:PG_OFF_W];

  tlb_match #(.N(N), .VPN_W(VPN_W)) u_lk_match (
    .key(lk_vpn), .valid(valid_q), .tags(tag_q),
    .match(lk_match), .any(lk_any), .idx(lk_idx)
  );

  assign hit       = lk_valid && lk_any;
  assign miss_exc  = lk_valid && !lk_any;
  assign pa        = hit ? join_pa(ppn_q[lk_idx], lk_vaddr) : '0;
  assign hit_dirty = hit && dirty_q[lk_idx];
  assign hit_ref   = hit && ref_q[lk_idx];

  // refill side
  logic [N-1:0]     same_match;
  logic             same_any;
  logic [IDX_W-1:0] same_idx;
  logic [IDX_W-1:0] vic_idx;
  vsel_e            vic_how;
  logic [IDX_W-1:0] fill_idx;
  logic [N-1:0]     fill_sel;

  tlb_match #(.N(N), .VPN_W(VPN_W)) u_fill_match (
    .key(fill_vpn), .valid(valid_q), .tags(tag_q),
    .match(same_match), .any(same_any), .idx(same_idx)
  );

  tlb_victim #(.N(N)) u_victim (
    .valid(valid_q), .refd(ref_q), .ptr(ptr_q),
    .vic_idx(vic_idx), .vic_how(vic_how)
  );

  assign fill_idx = same_any ? same_idx : vic_idx;

  // named events for the checks below
  logic [N-1:0] hit_vec, ref_touch, dirty_touch;
  logic         rotate_used;

  assign hit_vec     = lk_valid ? lk_match : '0;
  assign rotate_used = fill_en && !same_any && (vic_how == VS_ROTATE);

  for (genvar k = 0; k < N; k++) begin : g_sel
    assign fill_sel[k]    = fill_en && (fill_idx == IDX_W'(k));
    assign ref_touch[k]   = hit_vec[k] && !fill_sel[k];
    assign dirty_touch[k] = ref_touch[k] && lk_write;
  end

  // next-state of the status bits
  logic [N-1:0] ref_n, dirty_n;
  always_comb begin
    for (int k = 0; k < N; k++) begin
      ref_n[k]   = (ref_q[k] && !clr_ref) || hit_vec[k];
      dirty_n[k] = dirty_q[k] || (hit_vec[k] && lk_write);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      ref_q   <= '0;
      tag_q   <= '0;
      ppn_q   <= '0;
      ptr_q   <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (fill_sel[k]) begin
          valid_q[k] <= 1'b1;
          tag_q[k]   <= fill_vpn;
          ppn_q[k]   <= fill_ppn;
          dirty_q[k] <= fill_dirty;
          ref_q[k]   <= 1'b0;
        end else begin
          dirty_q[k] <= dirty_n[k];
          ref_q[k]   <= ref_n[k];
        end
      end
      if (rotate_used) ptr_q <= next_ptr(vic_idx);
    end
  end

  // assertions
  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && miss_exc));
  p_miss_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_exc |-> lk_valid);
  p_ref_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|ref_touch) |=> ((ref_q & $past(ref_touch)) == $past(ref_touch)));
  p_dirty_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|dirty_touch) |=> ((dirty_q & $past(dirty_touch)) == $past(dirty_touch)));
  p_clr_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ref && !(|hit_vec) && !fill_en) |=> (ref_q == '0));
  p_no_dup_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match) && $onehot0(same_match));
  p_fill_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (valid_q[$past(fill_idx)] && !ref_q[$past(fill_idx)]));
endmodule

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0, clr_ref = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        fill_en = 1'b0, fill_dirty = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [17:0] fill_ppn = '0;
  logic        hit, miss_exc, hit_dirty, hit_ref;
  logic [29:0] pa;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic        e_hit;
    logic [29:0] e_pa;
    logic        e_d;
    logic        e_r;
    int          req;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;

  always #(CLK_PER/2) clk = ~clk;

  tlb_xlate u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_vaddr(lk_vaddr), .clr_ref(clr_ref), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_dirty(fill_dirty),
    .hit(hit), .miss_exc(miss_exc), .pa(pa),
    .hit_dirty(hit_dirty), .hit_ref(hit_ref)
  );

  // monitor: pops one expectation per lookup and compares the ports
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (hit !== e.e_hit || miss_exc !== !e.e_hit || pa !== e.e_pa ||
            hit_dirty !== e.e_d || hit_ref !== e.e_r) begin
          errors++;
          $display("FAIL R%0d: got hit=%b miss=%b pa=%h d=%b r=%b, exp hit=%b miss=%b pa=%h d=%b r=%b",
                   e.req, hit, miss_exc, pa, hit_dirty, hit_ref,
                   e.e_hit, !e.e_hit, e.e_pa, e.e_d, e.e_r);
        end
      end
    end
  end

  // driver: one lookup cycle, expectation pushed for the monitor
  task automatic lookup(input logic [19:0] vpn, input logic [11:0] off,
                        input logic wr, input logic clr, input logic eh,
                        input logic [17:0] eppn, input logic ed,
                        input logic er, input int req);
    exp_t e;
    @(negedge clk);
    lk_valid = 1'b1;
    lk_write = wr;
    clr_ref  = clr;
    lk_vaddr = {vpn, off};
    e.e_hit = eh;
    e.e_pa  = eh ? {eppn, off} : 30'h0;
    e.e_d   = eh & ed;
    e.e_r   = eh & er;
    e.req   = req;
    #1;
    exp_q.push_back(e);
    ->chk_ev;
    @(posedge clk);
    #1;
    lk_valid = 1'b0;
    lk_write = 1'b0;
    clr_ref  = 1'b0;
  endtask

  task automatic miss(input logic [19:0] vpn, input int req);
    lookup(vpn, 12'h3C5, 1'b0, 1'b0, 1'b0, 18'h0, 1'b0, 1'b0, req);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [17:0] ppn,
                      input logic d);
    @(negedge clk);
    fill_en    = 1'b1;
    fill_vpn   = vpn;
    fill_ppn   = ppn;
    fill_dirty = d;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic clear_refs();
    @(negedge clk);
    clr_ref = 1'b1;
    @(negedge clk);
    clr_ref = 1'b0;
  endtask

  initial begin
    #(CLK_PER * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6: after reset nothing hits; R2: miss flags
    miss(20'h12345, 6);
    miss(20'h00000, 2);

    // R11 + R1: load one page, translate with varied offsets
    fill(20'h12345, 18'h2ABCD, 1'b0);
    lookup(20'h12345, 12'h678, 0, 0, 1, 18'h2ABCD, 0, 0, 1);
    // R3: stored reference now 1; this write hit sets dirty
    lookup(20'h12345, 12'hFFF, 1, 0, 1, 18'h2ABCD, 0, 1, 3);
    // R4: dirty visible after the write
    lookup(20'h12345, 12'h000, 0, 0, 1, 18'h2ABCD, 1, 1, 4);
    // R2: neighbouring page misses and changes nothing
    miss(20'h12346, 2);
    lookup(20'h12345, 12'h001, 0, 0, 1, 18'h2ABCD, 1, 1, 2);

    // R7: fill the remaining free slots 1..15
    for (int i = 1; i < 16; i++) fill(20'h00100 + 20'(i), 18'h01000 + 18'(i), 1'(i & 1));
    for (int i = 1; i < 15; i++)
      lookup(20'h00100 + 20'(i), 12'(i * 7), 0, 0, 1, 18'h01000 + 18'(i), 1'(i & 1), 0, 7);

    // R8: only slot 15 is unreferenced
    fill(20'h0AAAA, 18'h0AAAA, 1'b0);
    miss(20'h0010F, 8);
    lookup(20'h0AAAA, 12'h123, 0, 0, 1, 18'h0AAAA, 0, 0, 8);

    // R9: all referenced -> pointer 0 picks slot 0
    fill(20'h0BBBB, 18'h0BBBB, 1'b0);
    miss(20'h12345, 9);
    lookup(20'h00101, 12'h010, 0, 0, 1, 18'h01001, 1, 1, 9);

    // R8 ahead of R9: new slot 0 is unreferenced
    fill(20'h0CCCC, 18'h0CCCC, 1'b0);
    miss(20'h0BBBB, 8);
    lookup(20'h0CCCC, 12'h0C0, 0, 0, 1, 18'h0CCCC, 0, 0, 8);

    // R9: pointer advanced to 1
    fill(20'h0DDDD, 18'h0DDDD, 1'b0);
    miss(20'h00101, 9);
    lookup(20'h0DDDD, 12'h0D0, 0, 0, 1, 18'h0DDDD, 0, 0, 9);

    // R5: clear command zeroes reference bits
    clear_refs();
    lookup(20'h00105, 12'h555, 0, 0, 1, 18'h01005, 1, 0, 5);
    lookup(20'h00105, 12'h556, 0, 0, 1, 18'h01005, 1, 1, 5);

    // R8 after clear: lowest unreferenced is slot 0
    fill(20'h0EEEE, 18'h0EEEE, 1'b1);
    miss(20'h0CCCC, 8);
    lookup(20'h0EEEE, 12'hEEE, 0, 0, 1, 18'h0EEEE, 1, 0, 11);

    // R10: refill of a present page overwrites it in place
    fill(20'h00106, 18'h3FFFF, 1'b1);
    lookup(20'h00106, 12'hABC, 0, 0, 1, 18'h3FFFF, 1, 0, 10);
    lookup(20'h00107, 12'h007, 0, 0, 1, 18'h01007, 1, 0, 10);
    lookup(20'h0DDDD, 12'h0DD, 0, 0, 1, 18'h0DDDD, 0, 0, 10);

    // R5: clear and hit in one cycle, the hit entry stays referenced
    lookup(20'h00108, 12'h088, 0, 1, 1, 18'h01008, 0, 0, 5);
    lookup(20'h00108, 12'h089, 0, 0, 1, 18'h01008, 0, 1, 5);
    lookup(20'h00107, 12'h077, 0, 0, 1, 18'h01007, 1, 0, 5);

    // R6: reset mid-run invalidates everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    miss(20'h0EEEE, 6);
    miss(20'h00108, 6);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, exp 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule